// File: doc/BRIEF.md
# Opcode-Fetch Sequencer with Memory Refresh Counter

This block tracks the machine-cycle timing of an 8-bit processor's instruction fetch and keeps the dynamic-memory refresh register. The byte that arrives on the data bus at the last T-state of each machine cycle is decoded for prefix codes only. From that byte the block decides whether the next machine cycle is an opcode fetch (a 4-T-state M1 cycle) or a plain memory read. During T3 and T4 of every opcode fetch it raises a refresh strobe and drives a refresh address onto the bus. That address is the interrupt-vector high byte, supplied on an input, followed by the refresh register.

The low 7 bits of the refresh register form a counter. The counter advances once at the end of each opcode-fetch cycle, so a prefixed instruction advances it once per prefix plus once for its opcode. Operand and displacement bytes are read with plain cycles that do not touch the counter. The indexed bit-operation form, an index prefix followed by the bit-operation prefix, switches to plain reads after its second prefix. It stays on plain reads for its displacement and final opcode, and its cycle lengths add up to 23 T-states. An external decoder tells the block how many operand bytes follow each final opcode. Software can overwrite the whole register through a load port.

Top module: `refresh_fetch_seq`

## Requirements
- R1: While reset is low, the refresh register reads 0x00, `m1_o` is high, `tstate_o` is 1 and `rfsh_o` is low, so the first cycle after reset is T1 of an opcode fetch.
- R2: An opcode-fetch cycle lasts 4 T-states with `m1_o` high throughout. An ordinary plain read lasts 3 T-states with `m1_o` low. `cyc_last_o` marks the final T-state of every machine cycle.
- R3: `rfsh_o` is high exactly in T3 and T4 of each opcode-fetch cycle. While it is high, `rfsh_addr_o` equals {`ivec_hi`, refresh register}. At all other times `rfsh_addr_o` is zero.
- R4: The counter steps at the clock edge that ends each opcode-fetch cycle. Only bits 6..0 count, wrapping from 0x7F to 0x00, and bit 7 is never changed by a step. No other cycle changes the register.
- R5: An unprefixed opcode gives one step. Prefix codes 0xCB, 0xED, 0xDD and 0xFD are each fetched in an opcode-fetch cycle, so a single-prefix instruction gives two steps. A repeated index prefix (0xDD 0xDD op) gives three.
- R6: After an index prefix (0xDD or 0xFD), a 0xCB byte starts the indexed bit-operation form. The cycles that follow are plain reads of 3, 5, 4 and 3 T-states. The instruction totals 23 T-states and two steps, and `opnd_cnt` is ignored throughout it.
- R7: `opnd_cnt`, sampled at the end of an instruction's final opcode fetch, sets the number of following 3-T-state plain reads (0 to 3). None of these reads steps the counter.
- R8: A block-repeat instruction re-fetched N times (for example 0xED 0xB0 three times) steps the counter 2N times.
- R9: A load writes all 8 bits from `ld_val` at the next edge and takes priority over a step at the same edge.
- R10: After the 0xCB or 0xED prefix, the next byte is the final opcode even if it is 0xDD or 0xFD, and the instruction ends there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with the clock |
| fetch_byte | input | 8 | Byte on the data bus, sampled at the last T-state of each machine cycle |
| opnd_cnt | input | 2 | Number of operand bytes after the final opcode, sampled with it |
| ld_en | input | 1 | Refresh-register load request |
| ld_val | input | 8 | Value written by a load |
| ivec_hi | input | 8 | Upper byte of the refresh address |
| m1_o | output | 1 | High during every T-state of an opcode-fetch cycle |
| rfsh_o | output | 1 | Refresh strobe, T3 and T4 of opcode fetches |
| rfsh_addr_o | output | 16 | Refresh address while the strobe is high, zero otherwise |
| tstate_o | output | 3 | Current T-state number, starting at 1 |
| cyc_last_o | output | 1 | High in the final T-state of a machine cycle |
| rfsh_reg_o | output | 8 | Current refresh register |

## Verification
The embedded properties watch every cycle for these rules:
- bit 7 is kept unless a load occurs;
- the register stays unchanged outside opcode-fetch ends;
- a load wins over a step;
- opcode fetches end on T4;
- T3 with the strobe is always followed by T4 with the strobe;
- the T-state stays in range;
- the cycle kind is constant within a cycle;
- once plain reads start, opcode fetches return only with a fresh instruction.

What a property cannot show is which byte streams lead to which cycle sequence. That includes prefix chains, the 23-T-state indexed bit-operation form, operand counts, repeated block instructions, the 0x7F wrap and the exact register values after each instruction. These need the bench's instruction scenarios, checked cycle by cycle against an expected queue.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  localparam int LEN_W = 3;

  localparam logic [7:0] CODE_IDX_X  = 8'hDD;
  localparam logic [7:0] CODE_IDX_Y  = 8'hFD;
  localparam logic [7:0] CODE_BITOP  = 8'hCB;
  localparam logic [7:0] CODE_EXTOP  = 8'hED;

  localparam logic [LEN_W-1:0] LEN_OPFETCH = 3'd4;
  localparam logic [LEN_W-1:0] LEN_READ    = 3'd3;
  localparam logic [LEN_W-1:0] LEN_IDX_OP  = 3'd5;
  localparam logic [LEN_W-1:0] LEN_IDX_RMW = 3'd4;
  localparam logic [LEN_W-1:0] RFSH_FIRST_T = 3'd3;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_OPND,
    PH_IDX_DISP,
    PH_IDX_OP,
    PH_IDX_RMW,
    PH_IDX_WB
  } phase_e;

  typedef struct packed {
    logic             is_m1;
    logic [LEN_W-1:0] len;
  } mcyc_t;

  function automatic mcyc_t mk_cyc(input logic m1, input logic [LEN_W-1:0] len);
    mcyc_t c;
    c.is_m1 = m1;
    c.len   = len;
    return c;
  endfunction

endpackage

// File: rtl/rfs_tstate_counter.sv
module rfs_tstate_counter
  import refresh_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cyc_len,
  output logic [LEN_W-1:0] tcnt,
  output logic             cyc_last
);

  logic [LEN_W-1:0] tcnt_q;
  logic [LEN_W-1:0] tcnt_d;

  assign cyc_last = (tcnt_q == cyc_len);

  always_comb begin
    if (cyc_last) tcnt_d = LEN_W'(1);
    else          tcnt_d = tcnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= LEN_W'(1);
    else        tcnt_q <= tcnt_d;
  end

  assign tcnt = tcnt_q;

  AST_TSTATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt_q != '0) && (tcnt_q <= cyc_len)); // R2

endmodule

// File: rtl/rfs_cycle_classifier.sv
module rfs_cycle_classifier
  import refresh_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_last,
  input  logic [DATA_W-1:0] fetch_byte,
  input  logic [OPND_W-1:0] opnd_cnt,
  output logic              is_m1,
  output logic [LEN_W-1:0]  cyc_len
);

  mcyc_t             cyc_q, cyc_d;
  phase_e            ph_q, ph_d;
  logic              pix_q, pix_d;
  logic              pext_q, pext_d;
  logic [OPND_W-1:0] rem_q, rem_d;
  logic              is_idx, is_bitop, is_ext, begin_instr;

  assign is_idx   = (fetch_byte == DATA_W'(CODE_IDX_X)) || (fetch_byte == DATA_W'(CODE_IDX_Y));
  assign is_bitop = (fetch_byte == DATA_W'(CODE_BITOP));
  assign is_ext   = (fetch_byte == DATA_W'(CODE_EXTOP));

  always_comb begin
    cyc_d       = cyc_q;
    ph_d        = ph_q;
    pix_d       = pix_q;
    pext_d      = pext_q;
    rem_d       = rem_q;
    begin_instr = 1'b0;
    if (cyc_last) begin
      case (ph_q)
        PH_OPC: begin
          if (pix_q && is_bitop) begin
            cyc_d = mk_cyc(1'b0, LEN_READ);
            ph_d  = PH_IDX_DISP;
          end else if (!pext_q && is_idx) begin
            cyc_d = mk_cyc(1'b1, LEN_OPFETCH);
            pix_d = 1'b1;
          end else if (!pix_q && !pext_q && (is_bitop || is_ext)) begin
            cyc_d  = mk_cyc(1'b1, LEN_OPFETCH);
            pext_d = 1'b1;
          end else if (opnd_cnt != '0) begin
            cyc_d = mk_cyc(1'b0, LEN_READ);
            ph_d  = PH_OPND;
            rem_d = opnd_cnt - OPND_W'(1);
          end else begin
            begin_instr = 1'b1;
          end
        end
        PH_OPND: begin
          if (rem_q == '0) begin
            begin_instr = 1'b1;
          end else begin
            rem_d = rem_q - OPND_W'(1);
          end
        end
        PH_IDX_DISP: begin
          cyc_d = mk_cyc(1'b0, LEN_IDX_OP);
          ph_d  = PH_IDX_OP;
        end
        PH_IDX_OP: begin
          cyc_d = mk_cyc(1'b0, LEN_IDX_RMW);
          ph_d  = PH_IDX_RMW;
        end
        PH_IDX_RMW: begin
          cyc_d = mk_cyc(1'b0, LEN_READ);
          ph_d  = PH_IDX_WB;
        end
        default: begin
          begin_instr = 1'b1;
        end
      endcase
      if (begin_instr) begin
        cyc_d  = mk_cyc(1'b1, LEN_OPFETCH);
        ph_d   = PH_OPC;
        pix_d  = 1'b0;
        pext_d = 1'b0;
        rem_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= mk_cyc(1'b1, LEN_OPFETCH);
      ph_q   <= PH_OPC;
      pix_q  <= 1'b0;
      pext_q <= 1'b0;
      rem_q  <= '0;
    end else if (cyc_last) begin
      cyc_q  <= cyc_d;
      ph_q   <= ph_d;
      pix_q  <= pix_d;
      pext_q <= pext_d;
      rem_q  <= rem_d;
    end
  end

  assign is_m1   = cyc_q.is_m1;
  assign cyc_len = cyc_q.len;

  AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_last |=> $stable(cyc_q)); // R2

  AST_NO_M1_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_q.is_m1 && cyc_last) |=> (!cyc_q.is_m1 || (ph_q == PH_OPC && !pix_q && !pext_q))); // R6

endmodule

// File: rtl/rfs_refresh_reg.sv
module rfs_refresh_reg #(
  parameter int CNT_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           ld_en,
  input  logic [CNT_W:0] ld_val,
  output logic [CNT_W:0] rreg
);

  localparam int REG_W = CNT_W + 1;

  logic [REG_W-1:0] r_q;
  logic [REG_W-1:0] r_d;
  logic             r_en;

  assign r_en = ld_en | step;

  always_comb begin
    if (ld_en) r_d = ld_val;
    else       r_d = {r_q[REG_W-1], r_q[CNT_W-1:0] + CNT_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    r_q <= '0;
    else if (r_en) r_q <= r_d;
  end

  assign rreg = r_q;

  AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> (r_q[REG_W-1] == $past(r_q[REG_W-1]))); // R4

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !step) |=> $stable(r_q)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (r_q == $past(ld_val))); // R9

endmodule

// File: rtl/refresh_fetch_seq.sv
module refresh_fetch_seq
  import refresh_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int OPND_W = 2,
  parameter int HI_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         fetch_byte,
  input  logic [OPND_W-1:0]         opnd_cnt,
  input  logic                      ld_en,
  input  logic [CNT_W:0]            ld_val,
  input  logic [HI_W-1:0]           ivec_hi,
  output logic                      m1_o,
  output logic                      rfsh_o,
  output logic [HI_W+CNT_W:0]       rfsh_addr_o,
  output logic [LEN_W-1:0]          tstate_o,
  output logic                      cyc_last_o,
  output logic [CNT_W:0]            rfsh_reg_o
);

  localparam int REG_W  = CNT_W + 1;
  localparam int ADDR_W = HI_W + REG_W;

  logic             is_m1;
  logic [LEN_W-1:0] cyc_len;
  logic [LEN_W-1:0] tcnt;
  logic             cyc_last;
  logic             step;
  logic [REG_W-1:0] rreg;

  rfs_tstate_counter i_tstate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_len  (cyc_len),
    .tcnt     (tcnt),
    .cyc_last (cyc_last)
  );

  rfs_cycle_classifier #(
    .DATA_W (DATA_W),
    .OPND_W (OPND_W)
  ) i_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_last   (cyc_last),
    .fetch_byte (fetch_byte),
    .opnd_cnt   (opnd_cnt),
    .is_m1      (is_m1),
    .cyc_len    (cyc_len)
  );

  assign step = is_m1 & cyc_last;

  rfs_refresh_reg #(
    .CNT_W (CNT_W)
  ) i_rreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .rreg   (rreg)
  );

  logic rfsh_win;
  assign rfsh_win = is_m1 && (tcnt >= RFSH_FIRST_T);

  assign m1_o        = is_m1;
  assign rfsh_o      = rfsh_win;
  assign rfsh_addr_o = rfsh_win ? {ivec_hi, rreg} : ADDR_W'(0);
  assign tstate_o    = tcnt;
  assign cyc_last_o  = cyc_last;
  assign rfsh_reg_o  = rreg;

  AST_M1_ENDS_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m1 && cyc_last) |-> (tcnt == LEN_OPFETCH)); // R2

  AST_RFSH_T3_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_win && !cyc_last) |=> (rfsh_win && cyc_last)); // R3

endmodule

// File: tb/test_refresh_fetch_seq.sv
`timescale 1ns/1ps
module test_refresh_fetch_seq;

  typedef struct {
    logic [7:0] b;
    bit         m1;
    int         len;
    int         opnd;
    bit         ld;
    logic [7:0] ldv;
    bit         chk;
    logic [7:0] rexp;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fetch_byte = 8'h00;
  logic [1:0]  opnd_cnt = 2'd0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_val = 8'h00;
  logic [7:0]  ivec_hi = 8'hA5;
  logic        m1_o, rfsh_o, cyc_last_o;
  logic [15:0] rfsh_addr_o;
  logic [2:0]  tstate_o;
  logic [7:0]  rfsh_reg_o;

  item_t q[$];
  int    errors = 0;
  int    checks = 0;
  int    cnt = 0;
  int    rst_cycles = 0;
  bit    run = 1'b0;
  bit    pop_pend = 1'b0;
  bit    rpend = 1'b0;
  logic [7:0] rpend_v;
  string rpend_tag;
  logic [7:0] rmodel = 8'h00;

  always #4 clk = ~clk;

  refresh_fetch_seq i_refresh_fetch_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_byte  (fetch_byte),
    .opnd_cnt    (opnd_cnt),
    .ld_en       (ld_en),
    .ld_val      (ld_val),
    .ivec_hi     (ivec_hi),
    .m1_o        (m1_o),
    .rfsh_o      (rfsh_o),
    .rfsh_addr_o (rfsh_addr_o),
    .tstate_o    (tstate_o),
    .cyc_last_o  (cyc_last_o),
    .rfsh_reg_o  (rfsh_reg_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit m1, input int len, input int opnd, input string tag);
    item_t it;
    it.b = b; it.m1 = m1; it.len = len; it.opnd = opnd;
    it.ld = 1'b0; it.ldv = 8'h00; it.chk = 1'b0; it.rexp = 8'h00; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_reg(input logic [7:0] v, input string tag);
    q[q.size()-1].chk  = 1'b1;
    q[q.size()-1].rexp = v;
    q[q.size()-1].tag  = tag;
  endtask

  task automatic load_at_end(input logic [7:0] v);
    q[q.size()-1].ld  = 1'b1;
    q[q.size()-1].ldv = v;
  endtask

  task automatic push_idx_bitop(input logic [7:0] pfx);
    push(pfx,   1, 4, 0, "R6");
    push(8'hCB, 1, 4, 0, "R6");
    push(8'h05, 0, 3, 3, "R6");
    push(8'h06, 0, 5, 0, "R6");
    push(8'h00, 0, 4, 0, "R6");
    push(8'h00, 0, 3, 0, "R6");
  endtask

  // monitor and driver of the per-cycle bus, one process for ordering
  always @(negedge clk) begin
    if (!run) begin
      rst_cycles++;
      if (rst_cycles == 5) begin
        check(rfsh_reg_o == 8'h00, "R1", rfsh_reg_o, 0);
        check(m1_o == 1'b1, "R1", m1_o, 1);
        check(tstate_o == 3'd1, "R1", tstate_o, 1);
        check(rfsh_o == 1'b0, "R1", rfsh_o, 0);
        rst_n = 1'b1;
        run   = 1'b1;
      end
    end
    if (run) begin
      if (rpend) begin
        check(rfsh_reg_o == rpend_v, rpend_tag, rfsh_reg_o, rpend_v);
        rpend = 1'b0;
      end
      if (pop_pend) begin
        void'(q.pop_front());
        pop_pend = 1'b0;
      end
      ld_en = 1'b0;
      if (q.size() > 0) begin
        fetch_byte = q[0].b;
        opnd_cnt   = 2'(q[0].opnd);
      end else begin
        fetch_byte = 8'h00;
        opnd_cnt   = 2'd0;
      end
      cnt++;
      if (q.size() > 0) begin
        check(m1_o == q[0].m1, q[0].tag, m1_o, q[0].m1);
        check(rfsh_o == (q[0].m1 && cnt >= 3), "R3", rfsh_o, (q[0].m1 && cnt >= 3));
        if (q[0].m1 && cnt >= 3)
          check(rfsh_addr_o == {ivec_hi, rmodel}, "R3", rfsh_addr_o, {ivec_hi, rmodel});
        else
          check(rfsh_addr_o == 16'h0000, "R3", rfsh_addr_o, 0);
      end
      if (cyc_last_o) begin
        logic [7:0] nv;
        nv = rmodel;
        if (m1_o) nv = {rmodel[7], rmodel[6:0] + 7'd1};
        if (q.size() > 0) begin
          check(cnt == q[0].len, q[0].tag, cnt, q[0].len);
          check(rfsh_reg_o == rmodel, "R4", rfsh_reg_o, rmodel);
          if (q[0].ld) begin
            ld_en  = 1'b1;
            ld_val = q[0].ldv;
            nv     = q[0].ldv;
          end
          if (q[0].chk) begin
            rpend     = 1'b1;
            rpend_v   = q[0].rexp;
            rpend_tag = q[0].tag;
          end
          pop_pend = 1'b1;
        end
        rmodel = nv;
        cnt = 0;
      end
    end
  end

  initial begin
    // unprefixed with and without operands
    push(8'h00, 1, 4, 0, "R5");
    push(8'h3E, 1, 4, 1, "R7"); push(8'h55, 0, 3, 0, "R7");
    expect_reg(8'h02, "R7");
    push(8'h01, 1, 4, 2, "R7"); push(8'h34, 0, 3, 0, "R7"); push(8'h12, 0, 3, 0, "R7");
    expect_reg(8'h03, "R7");
    // single prefixes
    push(8'hCB, 1, 4, 0, "R5"); push(8'h07, 1, 4, 0, "R5");
    expect_reg(8'h05, "R5");
    push(8'hED, 1, 4, 0, "R5"); push(8'h44, 1, 4, 0, "R5");
    expect_reg(8'h07, "R5");
    push(8'hDD, 1, 4, 0, "R5"); push(8'h21, 1, 4, 2, "R5");
    push(8'h00, 0, 3, 0, "R7"); push(8'h40, 0, 3, 0, "R7");
    expect_reg(8'h09, "R5");
    // indexed bit operations: 4+4+3+5+4+3 = 23 T-states, two steps
    push_idx_bitop(8'hDD);
    expect_reg(8'h0B, "R6");
    push_idx_bitop(8'hFD);
    expect_reg(8'h0D, "R6");
    // index code after the extended prefix is a final opcode
    push(8'hED, 1, 4, 0, "R10"); push(8'hDD, 1, 4, 0, "R10"); push(8'h00, 1, 4, 0, "R10");
    expect_reg(8'h10, "R10");
    // repeated index prefix
    push(8'hDD, 1, 4, 0, "R5"); push(8'hDD, 1, 4, 0, "R5"); push(8'h21, 1, 4, 0, "R5");
    expect_reg(8'h13, "R5");
    // block repeat re-fetched three times
    for (int i = 0; i < 3; i++) begin
      push(8'hED, 1, 4, 0, "R8"); push(8'hB0, 1, 4, 0, "R8");
    end
    expect_reg(8'h19, "R8");
    // load coinciding with a step
    push(8'h00, 1, 4, 0, "R9"); load_at_end(8'hFE);
    expect_reg(8'hFE, "R9");
    // wrap of the low seven bits, top bit kept
    push(8'h00, 1, 4, 0, "R4");
    expect_reg(8'hFF, "R4");
    push(8'h00, 1, 4, 0, "R4");
    expect_reg(8'h80, "R4");
    // load on a plain read cycle
    push(8'h3E, 1, 4, 1, "R9"); push(8'h77, 0, 3, 0, "R9"); load_at_end(8'h35);
    expect_reg(8'h35, "R9");
    push(8'h00, 1, 4, 0, "R9");
    expect_reg(8'h36, "R9");
    push(8'h00, 1, 4, 0, "R2");

    begin
      bit done = 1'b0;
      for (int c = 0; c < 5000; c++) begin
        @(posedge clk);
        if (run && q.size() == 0 && !rpend && !pop_pend) begin
          done = 1'b1;
          break;
        end
      end
      if (!done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=0 items left", q.size());
      end
    end
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule